// File: doc/BRIEF.md
# Power-Loss Sector Write Guard

This block sits between a host byte receiver and a flash write engine. Host bytes arrive one per cycle on a valid/ready stream and are collected in a sector buffer. Only when the last byte of a sector has been taken does the block issue a single commit request to the engine. It then holds a busy flag until the engine confirms completion. The engine reads the buffered bytes back through a read port. The buffer is never written out one byte at a time.

A power-good input reports whether the external supply is still above its valid threshold. When it drops, the block refuses host bytes in that same cycle. A sector that is only partly received is dropped and counted. A commit already under way may still finish, but only inside a backup window that is measured in clock cycles. If the engine stays silent for the whole window, the write is flagged as not completed. After the power loss the block parks in a halted state and ignores every host and engine strobe. It leaves that state only through reset, even if power-good comes back.

Top module: `sector_write_guard`

## Requirements
- R1: After reset with power-good high: `in_ready`=1, `busy`=0, `wr_req`=0, `halted`=0, `backup_expired`=0, and both counters read 0.
- R2: The k-th byte accepted in a sector (k counted from 0) can be read back at buffer address k through `rd_addr`/`rd_data` once the sector is complete.
- R3: `wr_req` stays 0 while a sector is being filled. It is high for exactly one cycle: the cycle right after the clock edge that accepts the sector's last byte (byte index SECTOR_BYTES-1).
- R4: `busy` is 1 from the cycle `wr_req` rises until the clock edge at which `wr_done` is sampled high. While `busy` is 1, `in_ready` is 0. Each confirmed write increments `done_cnt` by one. A `wr_done` strobe while no write is outstanding has no effect.
- R5: When `pwr_good` is 0, `in_ready` is 0 in the same cycle, with no clock edge needed.
- R6: A power loss while a sector is partly filled (1 to SECTOR_BYTES-1 bytes taken) increments `abort_cnt` by one, issues no `wr_req`, and enters the halted state.
- R7: A power loss during an outstanding write keeps `busy` high until `wr_done`. That completion increments `done_cnt`, after which the block is halted with `backup_expired`=0.
- R8: While halted, `in_ready`, `wr_req` and `busy` stay 0. Host bytes and `wr_done` strobes change neither counter nor the buffer contents.
- R9: If `wr_done` does not arrive within BACKUP_CYCLES clock edges after the edge that samples the power loss, `backup_expired` becomes 1, `busy` drops, and the block halts. A later `wr_done` is ignored.
- R10: A return of `pwr_good` does not leave the halted state. Only an active-low `rst_n` does.
- R11: A power loss with no partly filled sector leaves `abort_cnt` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Host byte valid |
| in_data | input | 8 | Host byte |
| in_ready | output | 1 | Block accepts a host byte this cycle |
| pwr_good | input | 1 | External supply above valid threshold |
| wr_req | output | 1 | One-cycle sector commit request to the flash engine |
| wr_done | input | 1 | Flash engine reports the commit finished |
| rd_addr | input | $clog2(SECTOR_BYTES) | Engine read address into the sector buffer |
| rd_data | output | 8 | Buffer byte at `rd_addr` (combinational) |
| busy | output | 1 | Sector write outstanding |
| halted | output | 1 | Parked after power loss until reset |
| backup_expired | output | 1 | Backup window ran out before the write finished |
| abort_cnt | output | CNT_W | Sectors dropped while partly received |
| done_cnt | output | CNT_W | Sector writes confirmed complete |

## Verification
Each result has a fixed due cycle. `in_ready` reacts to `pwr_good` combinationally, so the bench checks it a fraction of a cycle after the change, before any edge. `wr_req`, `busy`, the counters and the halted state are registered and change at the edge that samples their cause, so the bench reads them at the falling edge that follows. The window expiry lands exactly BACKUP_CYCLES edges after the edge that samples the loss. The bench therefore checks `busy` one falling edge before that point and the expiry flag one falling edge after it. All inputs are driven at falling edges, so every sampled value belongs to a known edge.

// File: rtl/sector_write_guard.sv
module sector_write_guard #(
  parameter int SECTOR_BYTES  = 512,
  parameter int BACKUP_CYCLES = 500000,
  parameter int CNT_W         = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  input  logic [7:0]                      in_data,
  output logic                            in_ready,
  input  logic                            pwr_good,
  output logic                            wr_req,
  input  logic                            wr_done,
  input  logic [$clog2(SECTOR_BYTES)-1:0] rd_addr,
  output logic [7:0]                      rd_data,
  output logic                            busy,
  output logic                            halted,
  output logic                            backup_expired,
  output logic [CNT_W-1:0]                abort_cnt,
  output logic [CNT_W-1:0]                done_cnt
);
  localparam int AW = $clog2(SECTOR_BYTES);
  localparam int TW = $clog2(BACKUP_CYCLES + 1);

  typedef enum logic [1:0] {S_RECV, S_WRITE, S_BACKUP, S_HALT} state_t;

  state_t        state;
  logic [7:0]    buf_mem [SECTOR_BYTES];
  logic [AW-1:0] fill;
  logic [TW-1:0] timer;

  wire take      = in_valid && in_ready;
  wire last_byte = (fill == AW'(SECTOR_BYTES - 1));

  assign in_ready = (state == S_RECV) && pwr_good;
  assign busy     = (state == S_WRITE) || (state == S_BACKUP);
  assign halted   = (state == S_HALT);
  assign rd_data  = buf_mem[rd_addr];

  always_ff @(posedge clk)
    if (take) buf_mem[fill] <= in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= S_RECV;
      fill           <= '0;
      timer          <= '0;
      wr_req         <= 1'b0;
      backup_expired <= 1'b0;
      abort_cnt      <= '0;
      done_cnt       <= '0;
    end else begin
      wr_req <= 1'b0;
      case (state)
        S_RECV:
          if (!pwr_good) begin
            if (fill != '0) abort_cnt <= abort_cnt + 1'b1;
            fill  <= '0;
            state <= S_HALT;
          end else if (take) begin
            if (last_byte) begin
              fill   <= '0;
              wr_req <= 1'b1;
              state  <= S_WRITE;
            end else begin
              fill <= fill + 1'b1;
            end
          end
        S_WRITE:
          if (wr_done) begin
            done_cnt <= done_cnt + 1'b1;
            state    <= pwr_good ? S_RECV : S_HALT;
          end else if (!pwr_good) begin
            timer <= '0;
            state <= S_BACKUP;
          end
        S_BACKUP:
          if (wr_done) begin
            done_cnt <= done_cnt + 1'b1;
            state    <= S_HALT;
          end else if (timer == TW'(BACKUP_CYCLES - 1)) begin
            backup_expired <= 1'b1;
            state          <= S_HALT;
          end else begin
            timer <= timer + 1'b1;
          end
        default: ;
      endcase
    end
  end

  p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req);
  p_req_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> busy);
  p_busy_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
  p_dead_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |-> !in_ready);
  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(done_cnt) && $stable(abort_cnt) && !wr_req && !busy));
  p_expire_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(backup_expired) |-> (halted && !busy));
endmodule

// File: tb/sector_write_guard_test.sv
module sector_write_guard_test;
  localparam int PERIOD = 10;
  localparam int SB     = 512;
  localparam int WIN    = 40;
  localparam int AW     = $clog2(SB);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = '0;
  logic          in_ready;
  logic          pwr_good = 1'b1;
  logic          wr_req;
  logic          wr_done = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          busy, halted, backup_expired;
  logic [15:0]   abort_cnt, done_cnt;

  int total = 0;
  int bad   = 0;

  always #(PERIOD/2) clk = ~clk;

  sector_write_guard #(.SECTOR_BYTES(SB), .BACKUP_CYCLES(WIN), .CNT_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .pwr_good(pwr_good), .wr_req(wr_req), .wr_done(wr_done),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .halted(halted),
    .backup_expired(backup_expired), .abort_cnt(abort_cnt), .done_cnt(done_cnt));

  function automatic logic [7:0] pat(int i, int seed);
    return 8'((i * 13 + seed) ^ (i >> 3));
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; wr_done = 1'b0; pwr_good = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_bytes(int n, int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wr_req) check("R3 early wr_req", 1, 0);
      in_valid = 1'b1;
      in_data  = pat(i, seed);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_sector(int seed);
    send_bytes(SB, seed);
    check("R3 wr_req after last byte", wr_req, 1);
    check("R4 busy at commit", busy, 1);
    check("R4 ready low while busy", in_ready, 0);
    @(negedge clk);
    check("R3 wr_req one cycle", wr_req, 0);
  endtask

  task automatic check_buffer(int seed);
    int idx [4] = '{0, 1, SB/2 - 1, SB - 1};
    for (int k = 0; k < 4; k++) begin
      rd_addr = AW'(idx[k]);
      #1;
      check("R2 buffer byte", rd_data, pat(idx[k], seed));
    end
  endtask

  task automatic pulse_done();
    wr_done = 1'b1;
    @(negedge clk);
    wr_done = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 in_ready", in_ready, 1);
    check("R1 busy", busy, 0);
    check("R1 wr_req", wr_req, 0);
    check("R1 halted", halted, 0);
    check("R1 expired", backup_expired, 0);
    check("R1 abort_cnt", abort_cnt, 0);
    check("R1 done_cnt", done_cnt, 0);
  endtask

  task automatic t_normal();
    do_reset();
    pulse_done();
    check("R4 stray done ignored", done_cnt, 0);
    send_sector(5);
    check_buffer(5);
    repeat (6) @(negedge clk);
    check("R4 busy held", busy, 1);
    check("R4 ready held low", in_ready, 0);
    pulse_done();
    check("R4 busy released", busy, 0);
    check("R4 done_cnt 1", done_cnt, 1);
    check("R4 ready again", in_ready, 1);
    send_sector(91);
    check_buffer(91);
    pulse_done();
    check("R4 done_cnt 2", done_cnt, 2);
  endtask

  task automatic t_partial_loss();
    logic [7:0] keep;
    do_reset();
    send_bytes(100, 33);
    pwr_good = 1'b0;
    #1;
    check("R5 ready drops at once", in_ready, 0);
    @(negedge clk);
    check("R6 abort_cnt", abort_cnt, 1);
    check("R6 no wr_req", wr_req, 0);
    check("R6 halted", halted, 1);
    rd_addr = '0;
    #1;
    keep = rd_data;
    for (int i = 0; i < 20; i++) begin
      in_valid = 1'b1;
      in_data  = 8'(i + 200);
      wr_done  = i[0];
      @(negedge clk);
      if (wr_req || busy || in_ready) check("R8 quiet outputs", 1, 0);
    end
    in_valid = 1'b0; wr_done = 1'b0;
    check("R8 abort_cnt kept", abort_cnt, 1);
    check("R8 done_cnt kept", done_cnt, 0);
    #1;
    check("R8 buffer kept", rd_data, keep);
    pwr_good = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 still halted", halted, 1);
    check("R10 ready still low", in_ready, 0);
    do_reset();
    check("R10 reset clears halt", halted, 0);
  endtask

  task automatic t_loss_in_write();
    do_reset();
    send_sector(7);
    pwr_good = 1'b0;
    repeat (10) @(negedge clk);
    check("R7 busy through backup", busy, 1);
    pulse_done();
    check("R7 done_cnt", done_cnt, 1);
    check("R7 halted", halted, 1);
    check("R7 no expiry", backup_expired, 0);
    check("R11 abort_cnt unchanged", abort_cnt, 0);
  endtask

  task automatic t_timeout();
    do_reset();
    send_sector(60);
    pwr_good = 1'b0;
    repeat (WIN) @(negedge clk);
    check("R9 busy before window end", busy, 1);
    check("R9 not yet expired", backup_expired, 0);
    @(negedge clk);
    check("R9 expired", backup_expired, 1);
    check("R9 busy dropped", busy, 0);
    check("R9 halted", halted, 1);
    pulse_done();
    check("R9 late done ignored", done_cnt, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_normal();
    t_partial_loss();
    t_loss_in_write();
    t_timeout();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule